// File: doc/BRIEF.md
# Load Queue with Store-Order Violation Detection

This block keeps the in-flight loads of an out-of-order core in a circular buffer ordered by program order. Each entry carries the load's sequence number and, once the load has computed it, its effective address. Retirement frees entries from the oldest end. A pipeline flush drops every entry younger than a given sequence number from the youngest end.

When a store executes, the core hands over two things: the queue position that the store captured at its own allocation, and the store's address. The block then walks forward from that position towards the youngest load. It compares addresses at a coarse granularity, ignoring the low 8 bits. The first match is latched as an ordering violation. The core later reads that load out to trigger a replay.

Retire, flush and store-check each take one entry per clock. A busy output is high while any of them runs.

Top module: `load_queue`

## Requirements
- R1: After reset the queue is empty: count 0, head and tail at index 0, `lq_full` low, `busy` low, `viol_valid` low.
- R2: Storage has DEPTH+1 slots. An accepted allocation writes at `lq_tail`, and the tail then advances with wrap from index DEPTH to 0. `lq_full` is high exactly when the count equals DEPTH. An allocation while full is ignored.
- R3: A commit request pops entries from the head, one per clock, while the queue is non-empty and the head's sequence number is less than or equal to the commit number. `busy` is high while this runs.
- R4: A squash request removes entries from the tail, one per clock, while the queue is non-empty and the youngest entry's sequence number is greater than the squash number. It stops at the first entry that is not younger.
- R5: If squash and commit are requested in the same idle cycle, only the squash is performed. The head does not move.
- R6: A store-check scans from the given index forward, with wrap, up to the current tail. A load matches when its address shifted right by 8 equals the store address shifted right by 8.
- R7: Only the first match in scan order is reported on `viol_idx`/`viol_seq`, and the scan ends there.
- R8: A load whose address has not been written since its allocation never matches.
- R9: While a violation is latched and unread, a store-check request is dropped. No scan runs and `busy` stays low.
- R10: The violation stays on the outputs until `viol_read` is pulsed. That pulse clears `viol_valid` at the next clock edge.
- R11: A squash request arriving during a store-check scan aborts the scan and starts the squash. No violation is reported from the aborted scan.
- R12: Allocation is accepted only when the queue is idle (`busy` low), not full, and no squash, commit or check is requested in the same cycle. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated load |
| addr_valid | input | 1 | Write a load's effective address |
| addr_idx | input | IW | Entry receiving the address |
| addr_val | input | ADDR_W | Effective address |
| commit_valid | input | 1 | Retire request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Flush request |
| squash_seq | input | SEQ_W | Entries with a larger number are dropped |
| chk_valid | input | 1 | Store-check request |
| chk_idx | input | IW | Queue position captured by the store at allocation |
| chk_addr | input | ADDR_W | Store effective address |
| viol_read | input | 1 | Consume the latched violation |
| viol_valid | output | 1 | A violating load is latched |
| viol_idx | output | IW | Entry of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| busy | output | 1 | Commit, squash or check in progress |
| lq_full | output | 1 | No free entry |
| lq_count | output | CW | Number of occupied entries |
| lq_head | output | IW | Oldest entry index |
| lq_tail | output | IW | Next allocation index |

## Verification
The checker watches several properties on every clock:
- the count never passes DEPTH, and `lq_full` agrees with the count;
- the count never grows while the block is busy;
- the head stays put during the cycle after a squash, even when a commit arrives alongside it;
- a latched violation neither changes nor vanishes until it is read, and a read always clears it;
- a check dropped behind a latched violation never raises busy.

Some behaviours need sequences of traffic and only the bench scenarios show them:
- the scan order and its starting point;
- wraparound of the scan and of the pointers;
- the coarse address compare;
- the fact that loads without an address never match;
- the exact stopping points of commit and squash;
- the abort of a running check by a squash.

// File: rtl/lq_pkg.sv
package lq_pkg;

    typedef enum logic [1:0] {
        LQ_IDLE,
        LQ_COMMIT,
        LQ_SQUASH,
        LQ_CHECK
    } lq_state_e;

    // Circular index helpers over a queue of n slots
    function automatic int wrap_next(int i, int n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

    function automatic int wrap_prev(int i, int n);
        return (i == 0) ? n - 1 : i - 1;
    endfunction

endpackage

// File: rtl/lq_entry_file.sv
module lq_entry_file #(
    parameter int SLOTS  = 7,
    parameter int IW     = 3,
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_we,
    input  logic [IW-1:0]     alloc_idx,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              upd_we,
    input  logic [IW-1:0]     upd_idx,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [IW-1:0]     ra_idx,
    output logic [SEQ_W-1:0]  ra_seq,
    input  logic [IW-1:0]     rb_idx,
    output logic [SEQ_W-1:0]  rb_seq,
    input  logic [IW-1:0]     rc_idx,
    output logic [SEQ_W-1:0]  rc_seq,
    output logic [ADDR_W-1:0] rc_addr,
    output logic              rc_ok
);

    typedef struct packed {
        logic              ok;
        logic [ADDR_W-1:0] addr;
        logic [SEQ_W-1:0]  seq;
    } ent_t;

    ent_t ent_all [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        ent_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (upd_we && upd_idx == IW'(g)) begin
                slot_d.addr = upd_addr;
                slot_d.ok   = 1'b1;
            end
            // a fresh allocation overrides any address write to the same slot
            if (alloc_we && alloc_idx == IW'(g)) begin
                slot_d.seq  = alloc_seq;
                slot_d.addr = '0;
                slot_d.ok   = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign ent_all[g] = slot_q;
    end

    assign ra_seq  = ent_all[ra_idx].seq;
    assign rb_seq  = ent_all[rb_idx].seq;
    assign rc_seq  = ent_all[rc_idx].seq;
    assign rc_addr = ent_all[rc_idx].addr;
    assign rc_ok   = ent_all[rc_idx].ok;

endmodule

// File: rtl/lq_addr_match.sv
module lq_addr_match #(
    parameter int ADDR_W = 16,
    parameter int SHIFT  = 8
) (
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_ok,
    input  logic [ADDR_W-1:0] store_addr,
    output logic              hit
);

    logic [ADDR_W-1:0] load_blk, store_blk;

    assign load_blk  = load_addr >> SHIFT;
    assign store_blk = store_addr >> SHIFT;
    assign hit       = load_ok && (load_blk == store_blk);

endmodule

// File: rtl/load_queue.sv
module load_queue #(
    parameter int DEPTH  = 6,
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 16,
    parameter int SHIFT  = 8,
    localparam int SLOTS = DEPTH + 1,
    localparam int IW    = $clog2(SLOTS),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              addr_valid,
    input  logic [IW-1:0]     addr_idx,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              chk_valid,
    input  logic [IW-1:0]     chk_idx,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              viol_read,
    output logic              viol_valid,
    output logic [IW-1:0]     viol_idx,
    output logic [SEQ_W-1:0]  viol_seq,
    output logic              busy,
    output logic              lq_full,
    output logic [CW-1:0]     lq_count,
    output logic [IW-1:0]     lq_head,
    output logic [IW-1:0]     lq_tail
);
    import lq_pkg::*;

    typedef struct packed {
        lq_state_e         state;
        logic [IW-1:0]     head;
        logic [IW-1:0]     tail;
        logic [IW-1:0]     scan;
        logic [CW-1:0]     count;
        logic [SEQ_W-1:0]  cseq;
        logic [SEQ_W-1:0]  sseq;
        logic [ADDR_W-1:0] caddr;
        logic              vvalid;
        logic [IW-1:0]     vidx;
        logic [SEQ_W-1:0]  vseq;
    } ctl_t;

    ctl_t q, d;
    logic alloc_go;

    logic [IW-1:0]     tail_next, tail_prev, head_next, scan_next;
    logic [SEQ_W-1:0]  head_seq, last_seq, scan_seq;
    logic [ADDR_W-1:0] scan_addr;
    logic              scan_ok, scan_hit, full;

    assign tail_next = IW'(wrap_next(int'(q.tail), SLOTS));
    assign tail_prev = IW'(wrap_prev(int'(q.tail), SLOTS));
    assign head_next = IW'(wrap_next(int'(q.head), SLOTS));
    assign scan_next = IW'(wrap_next(int'(q.scan), SLOTS));
    assign full      = (tail_next == q.head);

    lq_entry_file #(
        .SLOTS(SLOTS), .IW(IW), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)
    ) u_ents (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_we  (alloc_go),
        .alloc_idx (q.tail),
        .alloc_seq (alloc_seq),
        .upd_we    (addr_valid),
        .upd_idx   (addr_idx),
        .upd_addr  (addr_val),
        .ra_idx    (q.head),
        .ra_seq    (head_seq),
        .rb_idx    (tail_prev),
        .rb_seq    (last_seq),
        .rc_idx    (q.scan),
        .rc_seq    (scan_seq),
        .rc_addr   (scan_addr),
        .rc_ok     (scan_ok)
    );

    lq_addr_match #(.ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_match (
        .load_addr  (scan_addr),
        .load_ok    (scan_ok),
        .store_addr (q.caddr),
        .hit        (scan_hit)
    );

    always_comb begin
        d        = q;
        alloc_go = 1'b0;
        if (viol_read) d.vvalid = 1'b0;
        unique case (q.state)
            LQ_IDLE: begin
                if (squash_valid) begin
                    d.state = LQ_SQUASH;
                    d.sseq  = squash_seq;
                end else if (commit_valid) begin
                    d.state = LQ_COMMIT;
                    d.cseq  = commit_seq;
                end else if (chk_valid) begin
                    if (!q.vvalid) begin
                        d.state = LQ_CHECK;
                        d.scan  = chk_idx;
                        d.caddr = chk_addr;
                    end
                end else if (alloc_valid && !full) begin
                    alloc_go = 1'b1;
                    d.tail   = tail_next;
                    d.count  = q.count + 1'b1;
                end
            end
            LQ_COMMIT: begin
                if (q.count != '0 && head_seq <= q.cseq) begin
                    d.head  = head_next;
                    d.count = q.count - 1'b1;
                end else begin
                    d.state = LQ_IDLE;
                end
            end
            LQ_SQUASH: begin
                if (q.count != '0 && last_seq > q.sseq) begin
                    d.tail  = tail_prev;
                    d.count = q.count - 1'b1;
                end else begin
                    d.state = LQ_IDLE;
                end
            end
            LQ_CHECK: begin
                if (squash_valid) begin
                    d.state = LQ_SQUASH;
                    d.sseq  = squash_seq;
                end else if (q.scan == q.tail) begin
                    d.state = LQ_IDLE;
                end else if (scan_hit) begin
                    d.vvalid = 1'b1;
                    d.vidx   = q.scan;
                    d.vseq   = scan_seq;
                    d.state  = LQ_IDLE;
                end else begin
                    d.scan = scan_next;
                end
            end
            default: d.state = LQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= LQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign viol_valid = q.vvalid;
    assign viol_idx   = q.vidx;
    assign viol_seq   = q.vseq;
    assign busy       = (q.state != LQ_IDLE);
    assign lq_full    = full;
    assign lq_count   = q.count;
    assign lq_head    = q.head;
    assign lq_tail    = q.tail;

endmodule

// File: rtl/lq_checker.sv
module lq_checker #(
    parameter int DEPTH = 6,
    parameter int IW    = 3,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          lq_full,
    input logic [CW-1:0] lq_count,
    input logic [IW-1:0] lq_head,
    input logic          squash_valid,
    input logic          commit_valid,
    input logic          chk_valid,
    input logic          viol_valid,
    input logic          viol_read,
    input logic [IW-1:0] viol_idx
);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lq_count <= CW'(DEPTH));

    assert_full_agrees_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lq_full == (lq_count == CW'(DEPTH)));

    assert_no_growth_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (lq_count <= $past(lq_count)));

    assert_squash_keeps_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && !busy) |=> $stable(lq_head));

    assert_viol_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !viol_read) |=> (viol_valid && $stable(viol_idx)));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_read) |=> !viol_valid);

    assert_dropped_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && chk_valid && !busy && !squash_valid && !commit_valid) |=> !busy);

endmodule

bind load_queue lq_checker #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_lq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .lq_full      (lq_full),
    .lq_count     (lq_count),
    .lq_head      (lq_head),
    .squash_valid (squash_valid),
    .commit_valid (commit_valid),
    .chk_valid    (chk_valid),
    .viol_valid   (viol_valid),
    .viol_read    (viol_read),
    .viol_idx     (viol_idx)
);

// File: tb/load_queue_test.sv
`timescale 1ns/1ps
module load_queue_test;
    localparam int DEPTH = 6;
    localparam int SL    = DEPTH + 1;

    logic clk = 0, rst_n = 0;
    logic alloc_valid = 0, addr_valid = 0, commit_valid = 0, squash_valid = 0;
    logic chk_valid = 0, viol_read = 0;
    logic [7:0]  alloc_seq = 0, commit_seq = 0, squash_seq = 0, viol_seq;
    logic [2:0]  addr_idx = 0, chk_idx = 0, viol_idx, lq_head, lq_tail, lq_count;
    logic [15:0] addr_val = 0, chk_addr = 0;
    logic viol_valid, busy, lq_full;

    always #2 clk = ~clk;

    load_queue uut (.*);

    int n_chk = 0, n_fail = 0;
    int mseq[SL], maddr[SL], mok[SL];
    int mhead = 0, mtail = 0, mcount = 0;
    int exp_idx[$], exp_seq[$];
    bit hold = 0, vpend = 0, rd_pend = 0, done = 0;

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic state_chk(string tag);
        check_eq({tag, " count"}, int'(lq_count), mcount);
        check_eq({tag, " head"}, int'(lq_head), mhead);
        check_eq({tag, " tail"}, int'(lq_tail), mtail);
        check_eq({tag, " full"}, int'(lq_full), int'(mcount == DEPTH));
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_alloc(int s);
        @(negedge clk); alloc_valid = 1; alloc_seq = 8'(s);
        @(negedge clk); alloc_valid = 0;
        if (mcount < DEPTH) begin
            mseq[mtail] = s; mok[mtail] = 0; maddr[mtail] = 0;
            mtail = (mtail + 1) % SL; mcount++;
        end
    endtask

    task automatic do_addr(int i, int a);
        @(negedge clk); addr_valid = 1; addr_idx = 3'(i); addr_val = 16'(a);
        @(negedge clk); addr_valid = 0;
        maddr[i] = a; mok[i] = 1;
    endtask

    task automatic do_commit(int s);
        @(negedge clk); commit_valid = 1; commit_seq = 8'(s);
        @(negedge clk); commit_valid = 0;
        check_eq("R3 busy during commit", int'(busy), 1);
        wait_idle();
        while (mcount != 0 && mseq[mhead] <= s) begin
            mhead = (mhead + 1) % SL; mcount--;
        end
    endtask

    task automatic do_squash(int s);
        @(negedge clk); squash_valid = 1; squash_seq = 8'(s);
        @(negedge clk); squash_valid = 0;
        wait_idle();
        while (mcount != 0 && mseq[(mtail + SL - 1) % SL] > s) begin
            mtail = (mtail + SL - 1) % SL; mcount--;
        end
    endtask

    task automatic do_check(int i, int a);
        bit dropped;
        dropped = vpend;
        @(negedge clk); chk_valid = 1; chk_idx = 3'(i); chk_addr = 16'(a);
        @(negedge clk); chk_valid = 0;
        if (dropped) check_eq("R9 dropped check keeps busy low", int'(busy), 0);
        if (!dropped) begin
            for (int p = i; p != mtail; p = (p + 1) % SL) begin
                if (mok[p] != 0 && (maddr[p] >> 8) == (a >> 8)) begin
                    exp_idx.push_back(p); exp_seq.push_back(mseq[p]); vpend = 1;
                    break;
                end
            end
        end
        wait_idle();
        repeat (3) @(negedge clk);
        if (!hold) check_eq("R6 expected violations consumed", exp_idx.size(), 0);
    endtask

    // monitor: consumes violations against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_pend) begin
                check_eq("R10 read clears violation", int'(viol_valid), 0);
                rd_pend = 0; viol_read = 0;
            end else if (viol_valid && !hold) begin
                if (exp_idx.size() == 0) begin
                    check_eq("R7 unexpected violation idx", int'(viol_idx), -1);
                end else begin
                    check_eq("R7 violation idx", int'(viol_idx), exp_idx.pop_front());
                    check_eq("R7 violation seq", int'(viol_seq), exp_seq.pop_front());
                end
                viol_read = 1; rd_pend = 1; vpend = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        state_chk("R1 reset");
        check_eq("R1 busy", int'(busy), 0);
        check_eq("R1 viol", int'(viol_valid), 0);
        rst_n = 1;
        @(negedge clk);

        do_alloc(10); do_alloc(11); do_alloc(12); do_alloc(13);
        state_chk("R2 after four allocs");
        do_addr(0, 'h1210); do_addr(1, 'h3400); do_addr(2, 'h12F0);

        do_check(1, 'h1255);          // R6: start at 1, idx2 matches coarsely
        do_check(0, 'h1299);          // R7: idx0 is first in order
        do_check(3, 'h0000);          // R8: idx3 has no address

        hold = 1;                     // R9: keep violation latched
        do_check(0, 'h34AA);
        do_check(2, 'h1200);
        check_eq("R9 violation still latched", int'(viol_valid), 1);
        hold = 0;
        repeat (4) @(negedge clk);
        check_eq("R9 only first violation", exp_idx.size(), 0);
        check_eq("R10 cleared after read", int'(viol_valid), 0);

        do_alloc(14); do_alloc(15);
        state_chk("R2 full");
        do_alloc(16);
        state_chk("R2 alloc when full ignored");

        do_commit(11);
        state_chk("R3 commit to 11");

        do_alloc(16); do_alloc(17);
        state_chk("R2 tail wrap");
        do_addr(6, 'h7700); do_addr(0, 'h5511);
        do_check(5, 'h5522);          // R6 scan wraps 5,6,0

        @(negedge clk); squash_valid = 1; squash_seq = 15; commit_valid = 1; commit_seq = 99;
        @(negedge clk); squash_valid = 0; commit_valid = 0;
        wait_idle();
        mtail = 6; mcount = 4;
        state_chk("R5 squash wins over commit");

        do_squash(13);
        state_chk("R4 squash stops at older");

        do_alloc(20); do_alloc(21);
        do_addr(4, 'h6600); do_addr(5, 'h6601);
        @(negedge clk); chk_valid = 1; chk_idx = 2; chk_addr = 'h66FF;
        @(negedge clk); chk_valid = 0; squash_valid = 1; squash_seq = 99;
        @(negedge clk); squash_valid = 0;
        wait_idle();
        repeat (6) @(negedge clk);
        check_eq("R11 aborted check reports nothing", int'(viol_valid), 0);
        state_chk("R11 squash removed none");

        @(negedge clk); commit_valid = 1; commit_seq = 12;
        @(negedge clk); commit_valid = 0; alloc_valid = 1; alloc_seq = 30;
        @(negedge clk); alloc_valid = 0;
        wait_idle();
        mhead = 3; mcount = 3;
        state_chk("R12 alloc while busy ignored");

        do_squash(0);
        state_chk("R4 squash all");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule